// File: doc/BRIEF.md
# Queue-Fed Expression Stack Executor

This block is the execution side of a decoupled interpreter. It takes instructions from the head of an instruction FIFO and operands from the head of an operand FIFO fed by the memory side. It evaluates postfix expressions on a private operand stack and returns results to the memory side through an output FIFO. Both input FIFOs are first-word-fall-through: a valid flag and the head word are presented, and the block pulses a pop strobe in the cycle it consumes the head.

Each instruction is one of four kinds. It can push a literal, push the next operand from memory, fold the top two stack entries with a 4-bit coded integer operator, or send the current top of stack. When the instruction FIFO is empty, the cycle is a no-operation. Stack overflow and underflow are caught: the offending instruction is dropped and a sticky error flag is raised. The flag stays up until reset.

Top module: `expr_stack_exec`

## Requirements
- R1: While `instr_valid_i` is low, the cycle is a no-operation. Neither FIFO is popped, and the stack and the error flag keep their values.
- R2: An instruction word holds the kind in bits [29:28] (0 push literal, 1 push from memory, 2 operate, 3 send), the operator code in bits [27:24] and a 24-bit literal in bits [23:0]. A push-literal places bits [23:0] on top of the stack.
- R3: A push-from-memory stalls while `opnd_valid_i` is low, popping nothing. In the first cycle `opnd_valid_i` is high, it pops the instruction and the operand together and places the operand on top.
- R4: An operate instruction takes the second-from-top entry as left operand L and the top entry as right operand R. It replaces both with one result, truncated to 24 bits. The operator codes are: 0 L+R, 1 L-R, 2 L&R, 3 L|R, 4 L^R, 5 L<<R[4:0], 6 L>>R[4:0] (logical), 7 L*R, 8 unsigned L<R (1/0), 9 L==R (1/0), 10 unsigned minimum, 11 unsigned maximum, 12 L&~R, 13 signed L<R (1/0), 14 L>>>R[4:0] (arithmetic), 15 L.
- R5: An accepted send copies the top of stack into the result register and leaves the stack unchanged. In the next cycle, `res_push_o` is high for exactly one cycle with `res_data_o` equal to that value.
- R6: A send stalls without popping while `res_full_i` is high, and in the cycle during which `res_push_o` is high. Two sends are therefore never pushed in consecutive cycles.
- R7: The stack holds DEPTH (16) entries. A push of either kind on a full stack is popped and discarded, and it sets the error flag. The stack is left unchanged and a push-from-memory does not consume an operand.
- R8: An operate with fewer than two entries, or a send with an empty stack, is popped and discarded at once, even while the output is full. It sets the error flag, leaves the stack unchanged and produces no push.
- R9: After reset the stack is empty, `err_o` is low and `res_push_o` is low. `err_o` rises in the cycle after a discarded instruction and stays high until reset.
- R10: An instruction that does not stall completes in the cycle it is presented, so back-to-back pushes complete at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction FIFO not empty |
| instr_i | input | 30 | Instruction FIFO head word |
| instr_pop_o | output | 1 | Consume instruction FIFO head this cycle |
| opnd_valid_i | input | 1 | Operand FIFO not empty |
| opnd_i | input | 24 | Operand FIFO head word |
| opnd_pop_o | output | 1 | Consume operand FIFO head this cycle |
| res_full_i | input | 1 | Output FIFO full |
| res_push_o | output | 1 | Write `res_data_o` into output FIFO |
| res_data_o | output | 24 | Result register |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench sweeps all sixteen operators over operand pairs chosen at the edges: zero, all ones, the sign bit, and shift amounts of 0, 23 and 31. A swapped operand order, or a shift that is not masked to five bits, shows up as a wrong sent value. A push-from-memory is held with no operand for several cycles, which catches a design that pops the instruction early or pushes a stale operand. The stack is filled to sixteen entries and pushed once more, and operate and send are tried on a short stack. A design that corrupts the stack, consumes an operand on a dropped push, or waits on a full output before dropping a send is seen through the value a later send returns and through the pop strobes. Back-to-back sends and a held full flag check that no result is pushed twice in a row or into a full queue.

// File: rtl/expr_exec_pkg.sv
`timescale 1ns/1ps
package expr_exec_pkg;
  localparam int unsigned KIND_W  = 2;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned DATA_W  = 24;
  localparam int unsigned INSTR_W = KIND_W + OP_W + DATA_W;

  typedef enum logic [KIND_W-1:0] {
    K_PUSH_IMM = 2'd0,
    K_PUSH_MEM = 2'd1,
    K_OPER     = 2'd2,
    K_SEND     = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_FOLD = 2'd2
  } stk_op_e;

  typedef enum logic [1:0] {
    WSEL_IMM = 2'd0,
    WSEL_MEM = 2'd1,
    WSEL_ALU = 2'd2
  } wsel_e;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd1;
  localparam logic [OP_W-1:0] OP_AND  = 4'd2;
  localparam logic [OP_W-1:0] OP_OR   = 4'd3;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd4;
  localparam logic [OP_W-1:0] OP_SHL  = 4'd5;
  localparam logic [OP_W-1:0] OP_SHR  = 4'd6;
  localparam logic [OP_W-1:0] OP_MUL  = 4'd7;
  localparam logic [OP_W-1:0] OP_LTU  = 4'd8;
  localparam logic [OP_W-1:0] OP_EQ   = 4'd9;
  localparam logic [OP_W-1:0] OP_MINU = 4'd10;
  localparam logic [OP_W-1:0] OP_MAXU = 4'd11;
  localparam logic [OP_W-1:0] OP_ANDN = 4'd12;
  localparam logic [OP_W-1:0] OP_LTS  = 4'd13;
  localparam logic [OP_W-1:0] OP_SRA  = 4'd14;
  localparam logic [OP_W-1:0] OP_LEFT = 4'd15;
endpackage

// File: rtl/exec_alu.sv
`timescale 1ns/1ps
module exec_alu
  import expr_exec_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned SH_W = 5;

  logic [SH_W-1:0] shamt;
  assign shamt = rhs_i[SH_W-1:0];

  always_comb begin
    res_o = lhs_i;
    unique case (op_i)
      OP_ADD:  res_o = lhs_i + rhs_i;
      OP_SUB:  res_o = lhs_i - rhs_i;
      OP_AND:  res_o = lhs_i & rhs_i;
      OP_OR:   res_o = lhs_i | rhs_i;
      OP_XOR:  res_o = lhs_i ^ rhs_i;
      OP_SHL:  res_o = lhs_i << shamt;
      OP_SHR:  res_o = lhs_i >> shamt;
      OP_MUL:  res_o = lhs_i * rhs_i;
      OP_LTU:  res_o = DATA_W'(lhs_i < rhs_i);
      OP_EQ:   res_o = DATA_W'(lhs_i == rhs_i);
      OP_MINU: res_o = (lhs_i < rhs_i) ? lhs_i : rhs_i;
      OP_MAXU: res_o = (lhs_i > rhs_i) ? lhs_i : rhs_i;
      OP_ANDN: res_o = lhs_i & ~rhs_i;
      OP_LTS:  res_o = DATA_W'($signed(lhs_i) < $signed(rhs_i));
      OP_SRA:  res_o = DATA_W'($signed(lhs_i) >>> shamt);
      OP_LEFT: res_o = lhs_i;
      default: res_o = lhs_i;
    endcase
  end
endmodule

// File: rtl/exec_stack.sv
`timescale 1ns/1ps
module exec_stack
  import expr_exec_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] top_o,
  output logic [DATA_W-1:0] nxt_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_idx, nxt_idx, free_idx;

  assign free_idx = PTR_W'(cnt_q);
  assign top_idx  = PTR_W'(cnt_q - CNT_W'(1));
  assign nxt_idx  = PTR_W'(cnt_q - CNT_W'(2));

  assign top_o = mem_q[top_idx];
  assign nxt_o = mem_q[nxt_idx];
  assign cnt_o = cnt_q;

  // storage carries no reset; the count guards every read
  always_ff @(posedge clk_i) begin
    unique case (op_i)
      STK_PUSH: mem_q[free_idx] <= wdata_i;
      STK_FOLD: mem_q[nxt_idx]  <= wdata_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: cnt_q <= cnt_q + CNT_W'(1);
        STK_FOLD: cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exec_decode.sv
`timescale 1ns/1ps
module exec_decode
  import expr_exec_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             instr_valid_i,
  input  kind_e            kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             opnd_valid_i,
  input  logic             out_busy_i,
  output logic             instr_pop_o,
  output logic             opnd_pop_o,
  output stk_op_e          stk_op_o,
  output wsel_e            wsel_o,
  output logic             send_o,
  output logic             err_o
);
  logic full, empty, short;

  assign full  = (cnt_i == CNT_W'(DEPTH));
  assign empty = (cnt_i == '0);
  assign short = (cnt_i < CNT_W'(2));

  always_comb begin
    instr_pop_o = 1'b0;
    opnd_pop_o  = 1'b0;
    stk_op_o    = STK_HOLD;
    wsel_o      = WSEL_IMM;
    send_o      = 1'b0;
    err_o       = 1'b0;
    if (instr_valid_i) begin
      unique case (kind_i)
        K_PUSH_IMM: begin
          instr_pop_o = 1'b1;
          if (full) err_o = 1'b1;
          else stk_op_o = STK_PUSH;
        end
        K_PUSH_MEM: begin
          wsel_o = WSEL_MEM;
          if (full) begin
            instr_pop_o = 1'b1;
            err_o       = 1'b1;
          end else if (opnd_valid_i) begin
            instr_pop_o = 1'b1;
            opnd_pop_o  = 1'b1;
            stk_op_o    = STK_PUSH;
          end
        end
        K_OPER: begin
          instr_pop_o = 1'b1;
          wsel_o      = WSEL_ALU;
          if (short) err_o = 1'b1;
          else stk_op_o = STK_FOLD;
        end
        K_SEND: begin
          // underflow drops at once, even while the output is busy
          if (empty) begin
            instr_pop_o = 1'b1;
            err_o       = 1'b1;
          end else if (!out_busy_i) begin
            instr_pop_o = 1'b1;
            send_o      = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exec_result.sv
`timescale 1ns/1ps
module exec_result
  import expr_exec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o
);
  logic              push_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= 1'b0;
      data_q <= '0;
    end else begin
      push_q <= send_i;
      if (send_i) data_q <= data_i;
    end
  end

  assign push_o = push_q;
  assign data_o = data_q;
endmodule

// File: rtl/expr_stack_exec.sv
`timescale 1ns/1ps
module expr_stack_exec
  import expr_exec_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               instr_pop_o,
  input  logic               opnd_valid_i,
  input  logic [DATA_W-1:0]  opnd_i,
  output logic               opnd_pop_o,
  input  logic               res_full_i,
  output logic               res_push_o,
  output logic [DATA_W-1:0]  res_data_o,
  output logic               err_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  kind_e             kind;
  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] lit;

  assign kind = kind_e'(instr_i[INSTR_W-1 -: KIND_W]);
  assign op   = instr_i[DATA_W +: OP_W];
  assign lit  = instr_i[DATA_W-1:0];

  stk_op_e           stk_op;
  wsel_e             wsel;
  logic              send, err_set, out_busy;
  logic [DATA_W-1:0] top, nxt, alu_res, wdata;
  logic [CNT_W-1:0]  cnt;
  logic              err_q;

  assign out_busy = res_full_i | res_push_o;

  exec_decode #(.DEPTH(DEPTH)) u_decode (
    .instr_valid_i(instr_valid_i),
    .kind_i       (kind),
    .cnt_i        (cnt),
    .opnd_valid_i (opnd_valid_i),
    .out_busy_i   (out_busy),
    .instr_pop_o  (instr_pop_o),
    .opnd_pop_o   (opnd_pop_o),
    .stk_op_o     (stk_op),
    .wsel_o       (wsel),
    .send_o       (send),
    .err_o        (err_set)
  );

  exec_alu u_alu (
    .op_i (op),
    .lhs_i(nxt),
    .rhs_i(top),
    .res_o(alu_res)
  );

  always_comb begin
    unique case (wsel)
      WSEL_MEM: wdata = opnd_i;
      WSEL_ALU: wdata = alu_res;
      default:  wdata = lit;
    endcase
  end

  exec_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (stk_op),
    .wdata_i(wdata),
    .top_o  (top),
    .nxt_o  (nxt),
    .cnt_o  (cnt)
  );

  exec_result u_result (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .send_i(send),
    .data_i(top),
    .push_o(res_push_o),
    .data_o(res_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/expr_stack_exec_chk.sv
`timescale 1ns/1ps
module expr_stack_exec_chk
  import expr_exec_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               instr_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               instr_pop_o,
  input logic               opnd_valid_i,
  input logic               opnd_pop_o,
  input logic               res_full_i,
  input logic               res_push_o,
  input logic               err_o
);
  logic [KIND_W-1:0] k;
  assign k = instr_i[INSTR_W-1 -: KIND_W];

  p_nop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> (!instr_pop_o && !opnd_pop_o));

  p_opnd_with_instr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_pop_o |-> (instr_pop_o && opnd_valid_i && k == 2'd1));

  p_push_after_send_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_push_o |-> $past(instr_valid_i && instr_pop_o && k == 2'd3));

  p_full_stalls_send_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && k == 2'd3 && res_full_i) |=> !res_push_o);

  p_push_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_push_o |=> !res_push_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind expr_stack_exec expr_stack_exec_chk u_chk (.*);

// File: tb/expr_stack_exec_tb.sv
`timescale 1ns/1ps
module expr_stack_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [29:0] instr = '0;
  logic        opnd_valid = 1'b0;
  logic [23:0] opnd = '0;
  logic        res_full = 1'b0;
  logic        instr_pop, opnd_pop, res_push, err;
  logic [23:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  expr_stack_exec u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .instr_valid_i(instr_valid),
    .instr_i      (instr),
    .instr_pop_o  (instr_pop),
    .opnd_valid_i (opnd_valid),
    .opnd_i       (opnd),
    .opnd_pop_o   (opnd_pop),
    .res_full_i   (res_full),
    .res_push_o   (res_push),
    .res_data_o   (res_data),
    .err_o        (err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [29:0] mk(input logic [1:0] k, input logic [3:0] op,
                                     input logic [23:0] lit);
    return {k, op, lit};
  endfunction

  function automatic logic [23:0] ref_op(input logic [3:0] op, input logic [23:0] a,
                                         input logic [23:0] b);
    logic [23:0] r;
    case (op)
      4'd0:  r = a + b;
      4'd1:  r = a - b;
      4'd2:  r = a & b;
      4'd3:  r = a | b;
      4'd4:  r = a ^ b;
      4'd5:  r = a << b[4:0];
      4'd6:  r = a >> b[4:0];
      4'd7:  r = a * b;
      4'd8:  r = (a < b) ? 24'd1 : 24'd0;
      4'd9:  r = (a == b) ? 24'd1 : 24'd0;
      4'd10: r = (a < b) ? a : b;
      4'd11: r = (a > b) ? a : b;
      4'd12: r = a & ~b;
      4'd13: r = ($signed(a) < $signed(b)) ? 24'd1 : 24'd0;
      4'd14: r = 24'($signed(a) >>> b[4:0]);
      default: r = a;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    opnd_valid = 1'b0;
    res_full = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present one instruction, wait until it is popped, then withdraw it
  task automatic issue(input logic [29:0] ins, output int stalls);
    stalls = 0;
    @(negedge clk);
    instr_valid = 1'b1;
    instr = ins;
    #1;
    while (!instr_pop) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 instr_valid = 1'b0;
  endtask

  task automatic send_exp(input logic [23:0] exp, input string req);
    int st;
    issue(mk(2'd3, 4'd0, 24'd0), st);
    @(negedge clk);
    chk(req, {31'd0, res_push}, 32'd1);
    chk(req, {8'd0, res_data}, {8'd0, exp});
  endtask

  localparam logic [23:0] A_V [6] = '{24'h000000, 24'h000005, 24'hFFFFFF,
                                      24'h800000, 24'h123456, 24'h7FFFFF};
  localparam logic [23:0] B_V [6] = '{24'h000000, 24'h000003, 24'h000001,
                                      24'h000017, 24'hFFFFFF, 24'h800000};

  initial begin
    int st;
    do_reset();

    // R9 reset state
    @(negedge clk);
    chk("R9 reset err", {31'd0, err}, 32'd0);
    chk("R9 reset push", {31'd0, res_push}, 32'd0);

    // R1 idle cycles: no pops even with an operand waiting
    issue(mk(2'd0, 4'd0, 24'hABCDEF), st);
    opnd_valid = 1'b1;
    opnd = 24'h111111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      chk("R1 idle instr_pop", {31'd0, instr_pop}, 32'd0);
      chk("R1 idle opnd_pop", {31'd0, opnd_pop}, 32'd0);
    end
    opnd_valid = 1'b0;
    send_exp(24'hABCDEF, "R1 stack kept");
    chk("R1 err kept", {31'd0, err}, 32'd0);

    // R2/R4 operator sweep
    for (int op = 0; op < 16; op++) begin
      for (int p = 0; p < 6; p++) begin
        do_reset();
        issue(mk(2'd0, 4'd0, A_V[p]), st);
        issue(mk(2'd0, 4'd0, B_V[p]), st);
        issue(mk(2'd2, 4'(op), 24'd0), st);
        send_exp(ref_op(4'(op), A_V[p], B_V[p]), "R4 operator");
      end
    end

    // R3 push from memory stalls until an operand arrives
    do_reset();
    @(negedge clk);
    instr_valid = 1'b1;
    instr = mk(2'd1, 4'd0, 24'd0);
    opnd = 24'h5A5A5A;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R3 stall instr_pop", {31'd0, instr_pop}, 32'd0);
      chk("R3 stall opnd_pop", {31'd0, opnd_pop}, 32'd0);
      @(negedge clk);
    end
    opnd_valid = 1'b1;
    #1;
    chk("R3 instr_pop", {31'd0, instr_pop}, 32'd1);
    chk("R3 opnd_pop", {31'd0, opnd_pop}, 32'd1);
    @(posedge clk);
    #1 instr_valid = 1'b0;
    opnd_valid = 1'b0;
    issue(mk(2'd0, 4'd0, 24'h000010), st);
    issue(mk(2'd2, 4'd1, 24'd0), st);
    send_exp(24'h5A5A4A, "R3 operand value");

    // R6 full output holds a send
    res_full = 1'b1;
    @(negedge clk);
    instr_valid = 1'b1;
    instr = mk(2'd3, 4'd0, 24'd0);
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R6 full stall", {31'd0, instr_pop}, 32'd0);
      chk("R6 full no push", {31'd0, res_push}, 32'd0);
      @(negedge clk);
    end
    res_full = 1'b0;
    #1;
    chk("R6 release", {31'd0, instr_pop}, 32'd1);
    @(posedge clk);
    #1 instr_valid = 1'b0;
    @(negedge clk);
    chk("R5 push", {31'd0, res_push}, 32'd1);
    chk("R5 data", {8'd0, res_data}, {8'd0, 24'h5A5A4A});

    // R6 back-to-back sends are spaced
    issue(mk(2'd3, 4'd0, 24'd0), st);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = mk(2'd3, 4'd0, 24'd0);
    #1;
    chk("R6 spacing push", {31'd0, res_push}, 32'd1);
    chk("R6 spacing stall", {31'd0, instr_pop}, 32'd0);
    @(negedge clk);
    #1;
    chk("R6 spacing gap", {31'd0, res_push}, 32'd0);
    chk("R6 second accepted", {31'd0, instr_pop}, 32'd1);
    @(posedge clk);
    #1 instr_valid = 1'b0;
    @(negedge clk);
    chk("R5 second push", {31'd0, res_push}, 32'd1);

    // R7/R10 fill to sixteen, then overflow
    do_reset();
    for (int i = 0; i < 16; i++) begin
      issue(mk(2'd0, 4'd0, 24'(100 + i)), st);
      chk("R10 one per cycle", 32'(st), 32'd0);
    end
    @(negedge clk);
    chk("R7 no err at full", {31'd0, err}, 32'd0);
    issue(mk(2'd0, 4'd0, 24'd999), st);
    chk("R7 overflow dropped", 32'(st), 32'd0);
    @(negedge clk);
    chk("R7 err", {31'd0, err}, 32'd1);
    opnd_valid = 1'b1;
    opnd = 24'h777777;
    instr_valid = 1'b1;
    instr = mk(2'd1, 4'd0, 24'd0);
    #1;
    chk("R7 mem push dropped", {31'd0, instr_pop}, 32'd1);
    chk("R7 operand kept", {31'd0, opnd_pop}, 32'd0);
    @(posedge clk);
    #1 instr_valid = 1'b0;
    opnd_valid = 1'b0;
    send_exp(24'd115, "R7 stack unchanged");
    chk("R9 err held", {31'd0, err}, 32'd1);

    // R8 underflow cases
    do_reset();
    issue(mk(2'd2, 4'd0, 24'd0), st);
    @(negedge clk);
    chk("R8 operate empty err", {31'd0, err}, 32'd1);

    do_reset();
    res_full = 1'b1;
    issue(mk(2'd3, 4'd0, 24'd0), st);
    chk("R8 send empty dropped", 32'(st), 32'd0);
    @(negedge clk);
    chk("R8 no push", {31'd0, res_push}, 32'd0);
    chk("R8 send empty err", {31'd0, err}, 32'd1);
    res_full = 1'b0;

    do_reset();
    issue(mk(2'd0, 4'd0, 24'd7), st);
    issue(mk(2'd2, 4'd0, 24'd0), st);
    @(negedge clk);
    chk("R8 operate short err", {31'd0, err}, 32'd1);
    send_exp(24'd7, "R8 stack unchanged");
    for (int i = 0; i < 3; i++) issue(mk(2'd0, 4'd0, 24'd1), st);
    @(negedge clk);
    chk("R9 err sticky", {31'd0, err}, 32'd1);

    do_reset();
    @(negedge clk);
    chk("R9 err cleared", {31'd0, err}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule